// File: doc/BRIEF.md
# Cycle-Steal Display Memory Arbiter

This block lets a host processor and a display refresh reader share one single-port, synchronous-read display memory of 19200 bytes. The internal main clock is split into fixed two-cycle slot pairs. The first cycle of each pair belongs to the host and the second to the display fetch.

A host access starts in one of two ways. In strobe mode it starts when chip select overlaps a read or write strobe. In wait-control mode it starts when a dedicated wait-control line falls while chip select is low. While the current line needs display data, the block stalls the host with an active-low WAIT until the access has finished. It then releases WAIT on a rising edge of the host clock. During the horizontal idle interval the host is never stalled, and it may also use an unclaimed display slot for full throughput.

Host addresses above 4AFFh are acknowledged but never reach the memory. The memory itself, the panel timing and any pixel processing sit outside this block; the memory connects through the `mem_*` port.

Top module: `cs_vram_arbiter`

## Requirements
- R1: During and directly after reset, `wait_n` is 1, `hrdata` is 0, `disp_valid` is 0 and `mem_en` is 0.
- R2: Slot cycles are counted from the first clock after reset release, starting at 0. Even cycles are host slots and odd cycles are display slots. A display fetch drives the memory only in an odd cycle, and while `line_active` is 1 a host access drives the memory only in an even cycle.
- R3: With `waitc_sel`=0, an access starts in the cycle where `cs_n`=0 together with `rd_n`=0 or `wr_n`=0 is first true after being false; `wr_n`=0 selects a write. If `line_active` is 1, `wait_n` is 0 from the next cycle.
- R4: With `waitc_sel`=1, the strobes alone start nothing. An access starts in the cycle where `waitc_n` first reads 0 after reading 1 while `cs_n`=0, and WAIT then falls as in R3.
- R5: `wait_n` returns to 1 only after the access has finished. It rises after the first clock edge at which `hclk` reads 1 having read 0 at the previous edge.
- R6: With `line_active`=1, a started access is performed in the first host slot after its start cycle. At most one host access is performed per slot pair.
- R7: With `line_active`=0, `wait_n` stays 1 for the whole access. The access reaches the memory in the cycle after its start cycle, unless a display fetch claims that cycle.
- R8: A read returns the addressed byte on `hrdata`. The value holds until the next host read completes, so it is stable while `rd_n` stays low.
- R9: A host address above 4AFFh never asserts `mem_en`. A write to it is dropped, a read of it returns 0, and WAIT is released as for any other access.
- R10: A display fetch occurs when `disp_req`=1 in an odd cycle: `mem_en` is asserted with `disp_addr` in that cycle. The fetched byte appears on `disp_data` with `disp_valid`=1 two cycles later, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hclk | input | 1 | Host clock level, sampled on `clk` |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| waitc_sel | input | 1 | 1 selects wait-control start mode |
| waitc_n | input | 1 | Wait-control line, falling edge starts an access |
| haddr | input | 15 | Host byte address |
| hwdata | input | 8 | Host write data |
| hrdata | output | 8 | Host read data |
| wait_n | output | 1 | Host stall, active low |
| line_active | input | 1 | 1 while the current line needs display transfer |
| disp_req | input | 1 | Display fetch request |
| disp_addr | input | 15 | Display fetch address |
| disp_data | output | 8 | Fetched display byte |
| disp_valid | output | 1 | `disp_data` is valid this cycle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_en` |

## Verification
A vector table drives reads and writes with `line_active` both high and low. This separates the stalled path, where WAIT must fall and then rise on a host clock edge, from the idle path, where WAIT never moves and the access lands in the next cycle. Addresses at 4AFFh, above it, and aliasing onto already written bytes show whether the range check, rather than the memory, decides what a read returns. Directed runs cover three more cases. Holding the strobes low in wait-control mode shows the strobes start nothing there. A single display fetch checks the two-cycle data latency. A host write under a continuous display request shows that the two sources never share a slot.

// File: rtl/csarb_pkg.sv
package csarb_pkg;
   localparam int ADDR_W   = 15;
   localparam int DATA_W   = 8;
   localparam int MEM_SIZE = 19200;

   typedef enum logic {
      SLOT_HOST = 1'b0,
      SLOT_DISP = 1'b1
   } slot_e;
endpackage

// File: rtl/csarb_slot_gen.sv
module csarb_slot_gen
   import csarb_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   output slot_e slot
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot <= SLOT_HOST;
      else        slot <= (slot == SLOT_HOST) ? SLOT_DISP : SLOT_HOST;
   end

   AST_SLOT_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> slot != $past(slot)); // R2
endmodule

// File: rtl/csarb_hclk_edge.sv
module csarb_hclk_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hclk,
   output logic rise
);
   logic hs;
   logic hs_q;

   initial begin
      AST_SYNC_RANGE: assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 3)
         else $error("SYNC_STAGES out of range"); // R5
   end

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign hs = hclk;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '0;
            else        ff <= (ff << 1) | SYNC_STAGES'(hclk);
         end
         assign hs = ff[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hs_q <= 1'b1;
      else        hs_q <= hs;
   end

   assign rise = hs & ~hs_q;
endmodule

// File: rtl/csarb_host_port.sv
module csarb_host_port #(
   parameter int               DW       = 8,
   parameter int               AW       = 15,
   parameter logic [AW-1:0]    MAX_ADDR = 15'h4AFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          waitc_sel,
   input  logic          waitc_n,
   input  logic [AW-1:0] haddr,
   input  logic [DW-1:0] hwdata,
   input  logic          line_active,
   input  logic          slot_ok,
   input  logic          hclk_rise,
   input  logic [DW-1:0] mem_rdata,
   output logic          grant,
   output logic          req_we,
   output logic          req_oor,
   output logic [AW-1:0] req_addr,
   output logic [DW-1:0] req_wdata,
   output logic          wait_n,
   output logic [DW-1:0] hrdata
);
   logic strb_act, strb_q, wc_q;
   logic start_raw, start, idle;
   logic pend_q, rdcap_q, fin_q, wait_q;

   assign strb_act  = !cs_n && (!rd_n || !wr_n);
   assign start_raw = waitc_sel ? (!cs_n && !waitc_n && wc_q)
                                : (strb_act && !strb_q);
   assign idle      = !pend_q && !rdcap_q && !fin_q && !wait_q;
   assign start     = start_raw && idle;
   assign grant     = pend_q && slot_ok;
   assign wait_n    = !wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q <= 1'b0;
         wc_q   <= 1'b1;
      end else begin
         strb_q <= strb_act;
         wc_q   <= waitc_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         rdcap_q   <= 1'b0;
         fin_q     <= 1'b0;
         wait_q    <= 1'b0;
         req_we    <= 1'b0;
         req_oor   <= 1'b0;
         req_addr  <= '0;
         req_wdata <= '0;
         hrdata    <= '0;
      end else begin
         if (start) begin
            pend_q    <= 1'b1;
            req_we    <= !wr_n;
            req_addr  <= haddr;
            req_wdata <= hwdata;
            req_oor   <= (haddr > MAX_ADDR);
            wait_q    <= line_active;
         end
         if (grant) begin
            pend_q  <= 1'b0;
            rdcap_q <= !req_we;
            if (req_we) fin_q <= 1'b1;
         end
         if (rdcap_q) begin
            rdcap_q <= 1'b0;
            hrdata  <= req_oor ? '0 : mem_rdata;
            fin_q   <= 1'b1;
         end
         if (fin_q && (!wait_q || hclk_rise)) begin
            fin_q  <= 1'b0;
            wait_q <= 1'b0;
         end
      end
   end

   AST_WAIT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      start && line_active |=> !wait_n); // R3
   AST_NO_WAIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wait_n) |-> $past(line_active)); // R7
   AST_RELEASE_ON_HCLK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wait_n) |-> $past(fin_q) && $past(hclk_rise)); // R5
   AST_ONE_PER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> !grant); // R6
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rdcap_q |=> $stable(hrdata)); // R8
endmodule

// File: rtl/csarb_disp_port.sv
module csarb_disp_port #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fetch,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] disp_data,
   output logic          disp_valid
);
   logic cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q      <= 1'b0;
         disp_valid <= 1'b0;
         disp_data  <= '0;
      end else begin
         cap_q      <= fetch;
         disp_valid <= cap_q;
         if (cap_q) disp_data <= mem_rdata;
      end
   end

   AST_DISP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |=> ##1 disp_valid); // R10
endmodule

// File: rtl/cs_vram_arbiter.sv
module cs_vram_arbiter
   import csarb_pkg::*;
#(
   parameter int AW          = ADDR_W,
   parameter int DW          = DATA_W,
   parameter int DEPTH       = MEM_SIZE,
   parameter int HCLK_SYNC   = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hclk,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          waitc_sel,
   input  logic          waitc_n,
   input  logic [AW-1:0] haddr,
   input  logic [DW-1:0] hwdata,
   output logic [DW-1:0] hrdata,
   output logic          wait_n,
   input  logic          line_active,
   input  logic          disp_req,
   input  logic [AW-1:0] disp_addr,
   output logic [DW-1:0] disp_data,
   output logic          disp_valid,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   localparam logic [AW-1:0] MAX_ADDR = AW'(DEPTH - 1);

   initial begin
      AST_DEPTH_FITS: assert (DEPTH > 0 && DEPTH <= (1 << AW))
         else $error("DEPTH does not fit address width"); // R9
      AST_DATA_WIDTH: assert (DW >= 1)
         else $error("DW must be positive"); // R8
   end

   slot_e         slot;
   logic          hclk_rise;
   logic          disp_grant, host_grant, slot_ok;
   logic          req_we, req_oor;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;

   assign disp_grant = disp_req && (slot == SLOT_DISP);
   assign slot_ok    = (slot == SLOT_HOST) || (!line_active && !disp_req);

   csarb_slot_gen u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (slot)
   );

   csarb_hclk_edge #(.SYNC_STAGES(HCLK_SYNC)) u_hedge (
      .clk   (clk),
      .rst_n (rst_n),
      .hclk  (hclk),
      .rise  (hclk_rise)
   );

   csarb_host_port #(.DW(DW), .AW(AW), .MAX_ADDR(MAX_ADDR)) u_host (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n        (cs_n),
      .rd_n        (rd_n),
      .wr_n        (wr_n),
      .waitc_sel   (waitc_sel),
      .waitc_n     (waitc_n),
      .haddr       (haddr),
      .hwdata      (hwdata),
      .line_active (line_active),
      .slot_ok     (slot_ok),
      .hclk_rise   (hclk_rise),
      .mem_rdata   (mem_rdata),
      .grant       (host_grant),
      .req_we      (req_we),
      .req_oor     (req_oor),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .wait_n      (wait_n),
      .hrdata      (hrdata)
   );

   csarb_disp_port #(.DW(DW)) u_disp (
      .clk        (clk),
      .rst_n      (rst_n),
      .fetch      (disp_grant),
      .mem_rdata  (mem_rdata),
      .disp_data  (disp_data),
      .disp_valid (disp_valid)
   );

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      if (disp_grant) begin
         mem_en   = 1'b1;
         mem_addr = disp_addr;
      end else if (host_grant && !req_oor) begin
         mem_en    = 1'b1;
         mem_we    = req_we;
         mem_addr  = req_addr;
         mem_wdata = req_wdata;
      end
   end

   AST_HOST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      host_grant && line_active |-> slot == SLOT_HOST); // R2
   AST_NO_SHARED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      disp_grant |-> !(mem_we)); // R2
   AST_OOR_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en && !disp_grant |-> mem_addr <= MAX_ADDR); // R9
endmodule

// File: tb/cs_vram_arbiter_tb.sv
module cs_vram_arbiter_tb;
   logic        clk = 1'b0, rst_n = 1'b0, hclk = 1'b0;
   logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic        waitc_sel = 1'b0, waitc_n = 1'b1;
   logic [14:0] haddr = '0, disp_addr = '0;
   logic [7:0]  hwdata = '0, hrdata, disp_data, mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        wait_n, line_active = 1'b0, disp_req = 1'b0, disp_valid;
   logic        mem_en, mem_we;
   logic [14:0] mem_addr;
   logic [7:0]  bmem [256];
   logic        ph, wprev;
   logic [1:0]  hs;
   int          n_chk = 0, n_fail = 0, hacc = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;
   initial begin
      #3;
      forever #8 hclk = ~hclk;
   end

   cs_vram_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .hclk(hclk), .cs_n(cs_n), .rd_n(rd_n),
      .wr_n(wr_n), .waitc_sel(waitc_sel), .waitc_n(waitc_n), .haddr(haddr),
      .hwdata(hwdata), .hrdata(hrdata), .wait_n(wait_n),
      .line_active(line_active), .disp_req(disp_req), .disp_addr(disp_addr),
      .disp_data(disp_data), .disp_valid(disp_valid), .mem_en(mem_en),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   // bench memory: synchronous read, one cycle latency, aliased on low byte
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) bmem[i] <= '0;
      end else if (mem_en) begin
         if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
         mem_rdata <= bmem[mem_addr[7:0]];
      end
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin ph <= 1'b0; hs <= 2'b11; end
      else begin ph <= ~ph; hs <= {hs[0], hclk}; end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // slot and release monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_en && disp_req && mem_addr == disp_addr)
            chk(ph == 1'b1, "R2 display fetch in odd slot", ph, 1);
         else if (mem_en) begin
            hacc++;
            if (line_active) chk(ph == 1'b0, "R2 R6 host access in even slot", ph, 0);
         end
         if (!wprev && wait_n)
            chk(hs == 2'b01, "R5 wait release on hclk rise", hs, 1);
      end
      wprev <= wait_n;
   end

   // {line_active, write, addr[14:0], data[7:0], expected read[7:0]}
   localparam logic [32:0] VEC [11] = '{
      {1'b1, 1'b1, 15'h0010, 8'hAA, 8'h00},
      {1'b1, 1'b0, 15'h0010, 8'h00, 8'hAA},
      {1'b0, 1'b1, 15'h0021, 8'h55, 8'h00},
      {1'b0, 1'b0, 15'h0021, 8'h00, 8'h55},
      {1'b1, 1'b1, 15'h4AFF, 8'h3C, 8'h00},
      {1'b1, 1'b0, 15'h4AFF, 8'h00, 8'h3C},
      {1'b1, 1'b1, 15'h4B00, 8'h77, 8'h00},
      {1'b1, 1'b0, 15'h0000, 8'h00, 8'h00},
      {1'b0, 1'b0, 15'h7FFF, 8'h00, 8'h00},
      {1'b0, 1'b1, 15'h1234, 8'hC3, 8'h00},
      {1'b1, 1'b0, 15'h1234, 8'h00, 8'hC3}
   };

   task automatic do_acc(input logic la, input logic wr, input logic [14:0] a,
                         input logic [7:0] d, input logic [7:0] ex, input logic wc);
      int n;
      @(negedge clk);
      line_active = la; waitc_sel = wc;
      haddr = a; hwdata = d; cs_n = 1'b0;
      if (wr) wr_n = 1'b0; else rd_n = 1'b0;
      if (wc) begin @(negedge clk); waitc_n = 1'b0; end
      @(negedge clk);
      if (la) chk(wait_n == 1'b0, "R3 R4 wait falls after start", wait_n, 0);
      else begin
         chk(wait_n == 1'b1, "R7 no wait while idle", wait_n, 1);
         if (a <= 15'h4AFF && !disp_req)
            chk(mem_en == 1'b1, "R7 idle access next cycle", mem_en, 1);
      end
      if (a > 15'h4AFF) chk(mem_en == 1'b0, "R9 out of range no mem_en", mem_en, 0);
      if (la) begin
         n = 0;
         while (!wait_n && n < 40) begin @(negedge clk); n++; end
         chk(wait_n == 1'b1, "R5 wait released", wait_n, 1);
      end else begin
         repeat (3) begin
            @(negedge clk);
            chk(wait_n == 1'b1, "R7 wait stays high", wait_n, 1);
         end
      end
      if (!wr) begin
         chk(hrdata == ex, (a > 15'h4AFF) ? "R9 out of range read zero" : "R8 read data", hrdata, ex);
         repeat (2) @(negedge clk);
         chk(hrdata == ex, "R8 read data held", hrdata, ex);
      end
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; waitc_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      int h0;
      repeat (3) @(negedge clk);
      chk(wait_n == 1'b1, "R1 reset wait_n", wait_n, 1);
      chk(hrdata == 8'h00, "R1 reset hrdata", hrdata, 0);
      chk(disp_valid == 1'b0, "R1 reset disp_valid", disp_valid, 0);
      chk(mem_en == 1'b0, "R1 reset mem_en", mem_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wait_n == 1'b1 && mem_en == 1'b0, "R1 after reset idle", {wait_n, mem_en}, 2);

      foreach (VEC[i])
         do_acc(VEC[i][32], VEC[i][31], VEC[i][30:16], VEC[i][15:8], VEC[i][7:0], 1'b0);

      // R4: strobes alone do nothing in wait-control mode
      @(negedge clk);
      line_active = 1'b1; waitc_sel = 1'b1; haddr = 15'h0010; cs_n = 1'b0; rd_n = 1'b0;
      h0 = hacc;
      repeat (3) @(negedge clk);
      chk(wait_n == 1'b1 && hacc == h0, "R4 strobes ignored in wait-control mode", hacc - h0, 0);
      cs_n = 1'b1; rd_n = 1'b1;
      repeat (2) @(negedge clk);
      do_acc(1'b1, 1'b0, 15'h0010, 8'h00, 8'hAA, 1'b1);
      waitc_sel = 1'b0;

      // R10: single display fetch latency
      @(negedge clk);
      while (ph != 1'b1) @(negedge clk);
      disp_addr = 15'h0010; disp_req = 1'b1;
      @(negedge clk);
      disp_req = 1'b0;
      chk(disp_valid == 1'b0, "R10 not valid one cycle after fetch", disp_valid, 0);
      @(negedge clk);
      chk(disp_valid == 1'b1, "R10 valid two cycles after fetch", disp_valid, 1);
      chk(disp_data == 8'hAA, "R10 fetched data", disp_data, 8'hAA);
      @(negedge clk);
      chk(disp_valid == 1'b0, "R10 valid lasts one cycle", disp_valid, 0);

      // R2 R6: host write under continuous display requests
      disp_addr = 15'h0021; disp_req = 1'b1;
      do_acc(1'b1, 1'b1, 15'h0030, 8'h5A, 8'h00, 1'b0);
      do_acc(1'b1, 1'b0, 15'h0030, 8'h00, 8'h5A, 1'b0);
      disp_req = 1'b0;
      do_acc(1'b0, 1'b0, 15'h0030, 8'h00, 8'h5A, 1'b0);

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule